// File: doc/BRIEF.md
# Token-convergence regional sum engine

This block counts the marked pixels of a rectangular pixel array whose pixels are linked into a single spanning tree. No pixel contains an adder. Each pixel holds at most one token of the current weight. Each clock, tokens hop one step toward the tree root. The pixel array is then treated as a checkerboard, and neighbouring tokens are merged in pairs into tokens of twice the weight. Merging in pairs never changes the parity of the token count, so when at most one current-weight token is left, its presence at the root is the next bit of the count. Bits come out least significant first, one round per bit, until no tokens of any weight remain.

A second mode gives the OR of the seed map. It runs one propagation phase and no pairing, and reports whether any token reached the root. A caller provides a parent direction for each pixel, a one-hot root map and a seed map, pulses `start`, then collects serial bits on `res_bit` while `res_valid` is high, with `done` marking the last bit. Building the tree is the caller's job. The tree and the root map must stay stable while the block is busy.

Top module: `token_sum_engine`

## Requirements
- R1: `start` seen while idle loads one token into each pixel whose `seed_map` bit is 1 and latches `mode_or`. `start` seen while busy has no effect on the run in progress or on its result.
- R2: During propagation, a token in a non-root pixel moves one hop per clock into its parent's slot when that slot was empty at the start of the cycle. Only a newly injected held token adds to the token count; the count never otherwise changes.
- R3: Parent direction codes are 0 = north (row-1), 1 = east (col+1), 2 = south (row+1) and 3 = west (col-1). Pixel index is row*COLS+col. When several children compete for one empty parent, the child to the north wins, then east, then south, then west. A child that loses keeps its token and retries.
- R4: A pairing step follows each settled propagation. A white pixel (row+col even) whose token sits next to a token in the neighbour at the step's direction merges with it. The direction rotates north, east, south, west over successive steps. Both tokens leave, and one token of double weight is added to the white pixel's held count, so the parity of the token count is kept.
- R5: A bit round ends when propagation has settled, at most one current-weight token remains and no held tokens of that weight await injection. The output bit is 1 exactly when that token sits at the root, and `res_valid` is a one-cycle pulse.
- R6: In sum mode, the bits read LSB first equal the number of seeded pixels. The bit count equals the bit length of that number, with a single 0 bit for an empty seed map.
- R7: `done` pulses with the final bit, which is the bit emitted when no held tokens of higher weight remain. The block then returns to idle.
- R8: In OR mode, one propagation phase runs and exactly one bit is produced, equal to the OR of the seed map, with `done`.
- R9: Synchronous reset clears all tokens and returns the block to idle with `res_valid` and `done` low, including during a run.
- R10: When a pixel holds a current-weight token and also has a held token of the same weight waiting, the two merge in place during a pairing step into one double-weight held token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled only while idle) |
| mode_or | input | 1 | 0 = count seeded pixels, 1 = OR of seeds |
| seed_map | input | ROWS*COLS | One bit per pixel: pixel starts with a token |
| root_map | input | ROWS*COLS | One-hot marker of the tree root |
| parent_dir | input | 2*ROWS*COLS | Two-bit parent direction per pixel, pixel p at bits 2p+1:2p |
| res_bit | output | 1 | Current result bit |
| res_valid | output | 1 | One-cycle strobe, `res_bit` is valid |
| done | output | 1 | Strobes with the final result bit |

## Verification
Several internal faults show up at the ports. A token that is lost or duplicated during a hop, during arbitration or during a merge changes the count, and from that round on every result bit of that weight or above can be wrong. The bench sees this as a wrong value or a wrong number of bits within one run. A pairing step that misses its partners, or a direction rotation that stalls, leaves two tokens stranded. The block then never reaches the end of the round, and the per-run cycle limit catches it. A result bit read from any pixel other than the root gives an error in the OR runs, where several tokens stay piled near the root.

// File: rtl/tse_pkg.sv
package tse_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_PAIR = 2'd2,
    ST_EMIT = 2'd3
  } phase_e;
endpackage

// File: rtl/tse_move.sv
// One propagation step: each non-root token may hop to its parent if that
// slot is empty; competing children are resolved by fixed priority N>E>S>W.
// Empty slots with held tokens waiting inject one of them.
module tse_move #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic [ROWS*COLS-1:0]   cur,
  input  logic [2*ROWS*COLS-1:0] parent_dir,
  input  logic [ROWS*COLS-1:0]   root_map,
  input  logic [ROWS*COLS-1:0]   pend_nz,
  output logic [ROWS*COLS-1:0]   cur_next,
  output logic [ROWS*COLS-1:0]   inj,
  output logic                   act
);
  localparam int NPIX = ROWS * COLS;

  logic [3:0]      gnt [NPIX];
  logic [NPIX-1:0] take;
  logic [NPIX-1:0] leave;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int P = r * COLS + c;
      logic [3:0] req;
      logic [3:0] lv;
      for (genvar d = 0; d < 4; d++) begin : g_dir
        localparam int NR = (d == 0) ? r - 1 : ((d == 2) ? r + 1 : r);
        localparam int NC = (d == 1) ? c + 1 : ((d == 3) ? c - 1 : c);
        localparam bit INB = (NR >= 0) && (NR < ROWS) && (NC >= 0) && (NC < COLS);
        localparam int Q = INB ? NR * COLS + NC : 0;
        if (INB) begin : g_in
          // neighbour Q wants to hop into P when its parent points back at P
          assign req[d] = cur[Q] & ~root_map[Q] &
                          (parent_dir[2*Q +: 2] == 2'(d ^ 2));
          // P leaves when its parent Q granted the direction pointing to P
          assign lv[d]  = (parent_dir[2*P +: 2] == 2'(d)) &
                          gnt[Q][d ^ 2] & ~cur[Q];
        end else begin : g_edge
          assign req[d] = 1'b0;
          assign lv[d]  = 1'b0;
        end
      end
      assign gnt[P]      = req & (~req + 4'd1);
      assign take[P]     = (|req) & ~cur[P];
      assign leave[P]    = cur[P] & ~root_map[P] & (|lv);
      assign inj[P]      = ~cur[P] & ~take[P] & pend_nz[P];
      assign cur_next[P] = (cur[P] & ~leave[P]) | take[P] | inj[P];
    end
  end

  assign act = (|take) | (|inj);
endmodule

// File: rtl/tse_pair.sv
// One pairing step on the checkerboard. The white pixel (row+col even)
// pairs with its neighbour in the step direction; a token with a same-weight
// held token in the same pixel merges in place.
module tse_pair #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic [ROWS*COLS-1:0] cur,
  input  logic [ROWS*COLS-1:0] pend_nz,
  input  logic [1:0]           dir,
  output logic [ROWS*COLS-1:0] cur_next,
  output logic [ROWS*COLS-1:0] hold_inc,
  output logic [ROWS*COLS-1:0] pend_dec
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int P = r * COLS + c;
      localparam bit WHITE = ((r + c) % 2) == 0;
      logic [3:0] hit;
      logic       paired;
      logic       inplace;
      for (genvar d = 0; d < 4; d++) begin : g_dir
        localparam int NR = (d == 0) ? r - 1 : ((d == 2) ? r + 1 : r);
        localparam int NC = (d == 1) ? c + 1 : ((d == 3) ? c - 1 : c);
        localparam bit INB = (NR >= 0) && (NR < ROWS) && (NC >= 0) && (NC < COLS);
        localparam int Q = INB ? NR * COLS + NC : 0;
        localparam int SEL = WHITE ? d : (d ^ 2);
        if (INB) begin : g_in
          assign hit[d] = cur[P] & cur[Q] & (dir == 2'(SEL));
        end else begin : g_edge
          assign hit[d] = 1'b0;
        end
      end
      assign paired      = |hit;
      assign inplace     = cur[P] & pend_nz[P] & ~paired;
      assign hold_inc[P] = (WHITE & paired) | inplace;
      assign pend_dec[P] = inplace;
      assign cur_next[P] = cur[P] & ~(paired | inplace);
    end
  end
endmodule

// File: rtl/tse_ctrl.sv
// Phase sequencer: settle propagation, pair, repeat; emit a bit per round.
module tse_ctrl
  import tse_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       mode_q,
  input  logic       act,
  input  logic       tok_le1,
  input  logic       pend_any,
  input  logic       hold_any,
  output phase_e     phase,
  output logic [1:0] pair_dir
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= ST_IDLE;
      pair_dir <= 2'd0;
    end else begin
      unique case (phase)
        ST_IDLE: begin
          if (start) begin
            phase    <= ST_MOVE;
            pair_dir <= 2'd0;
          end
        end
        ST_MOVE: begin
          if (!act) begin
            if (mode_q || (tok_le1 && !pend_any)) phase <= ST_EMIT;
            else                                  phase <= ST_PAIR;
          end
        end
        ST_PAIR: begin
          phase    <= ST_MOVE;
          pair_dir <= pair_dir + 2'd1;
        end
        ST_EMIT: begin
          phase <= (mode_q || !hold_any) ? ST_IDLE : ST_MOVE;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/token_sum_engine.sv
module token_sum_engine
  import tse_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   mode_or,
  input  logic [ROWS*COLS-1:0]   seed_map,
  input  logic [ROWS*COLS-1:0]   root_map,
  input  logic [2*ROWS*COLS-1:0] parent_dir,
  output logic                   res_bit,
  output logic                   res_valid,
  output logic                   done
);
  localparam int NPIX = ROWS * COLS;
  localparam int CW   = $clog2(NPIX / 2 + 1);

  phase_e          phase;
  logic [1:0]      pair_dir;
  logic            mode_q;
  logic [NPIX-1:0] cur_q;
  logic [CW-1:0]   pend_q [NPIX];
  logic [CW-1:0]   hold_q [NPIX];

  logic [NPIX-1:0] pend_nz;
  logic            pend_any;
  logic            hold_any;
  logic            tok_le1;
  logic            act;
  logic [NPIX-1:0] mv_cur, inj_v;
  logic [NPIX-1:0] pr_cur, hinc, pdec;

  always_comb begin
    hold_any = 1'b0;
    for (int p = 0; p < NPIX; p++) begin
      pend_nz[p] = (pend_q[p] != '0);
      hold_any   = hold_any | (hold_q[p] != '0);
    end
  end
  assign pend_any = |pend_nz;
  assign tok_le1  = ((cur_q & (cur_q - NPIX'(1))) == '0);

  tse_move #(.ROWS(ROWS), .COLS(COLS)) u_move (
    .cur(cur_q), .parent_dir(parent_dir), .root_map(root_map),
    .pend_nz(pend_nz), .cur_next(mv_cur), .inj(inj_v), .act(act)
  );

  tse_pair #(.ROWS(ROWS), .COLS(COLS)) u_pair (
    .cur(cur_q), .pend_nz(pend_nz), .dir(pair_dir),
    .cur_next(pr_cur), .hold_inc(hinc), .pend_dec(pdec)
  );

  tse_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mode_q(mode_q), .act(act),
    .tok_le1(tok_le1), .pend_any(pend_any), .hold_any(hold_any),
    .phase(phase), .pair_dir(pair_dir)
  );

  // token slots and held-token counters
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      mode_q <= 1'b0;
      for (int p = 0; p < NPIX; p++) begin
        pend_q[p] <= '0;
        hold_q[p] <= '0;
      end
    end else begin
      unique case (phase)
        ST_IDLE: begin
          if (start) begin
            cur_q  <= seed_map;
            mode_q <= mode_or;
            for (int p = 0; p < NPIX; p++) begin
              pend_q[p] <= '0;
              hold_q[p] <= '0;
            end
          end
        end
        ST_MOVE: begin
          cur_q <= mv_cur;
          for (int p = 0; p < NPIX; p++)
            pend_q[p] <= pend_q[p] - CW'(inj_v[p]);
        end
        ST_PAIR: begin
          cur_q <= pr_cur;
          for (int p = 0; p < NPIX; p++) begin
            pend_q[p] <= pend_q[p] - CW'(pdec[p]);
            hold_q[p] <= hold_q[p] + CW'(hinc[p]);
          end
        end
        ST_EMIT: begin
          cur_q <= '0;
          for (int p = 0; p < NPIX; p++) begin
            pend_q[p] <= hold_q[p];
            hold_q[p] <= '0;
          end
        end
        default: cur_q <= '0;
      endcase
    end
  end

  // registered serial result
  always_ff @(posedge clk) begin
    if (rst) begin
      res_bit   <= 1'b0;
      res_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      done      <= 1'b0;
      if (phase == ST_EMIT) begin
        res_bit   <= |(cur_q & root_map);
        res_valid <= 1'b1;
        done      <= mode_q | ~hold_any;
      end
    end
  end
endmodule

// File: rtl/tse_checker.sv
module tse_checker
  import tse_pkg::*;
#(
  parameter int NPIX = 64
) (
  input logic            clk,
  input logic            rst,
  input phase_e          phase,
  input logic            mode_q,
  input logic [NPIX-1:0] cur_q,
  input logic [NPIX-1:0] inj_v,
  input logic [NPIX-1:0] pdec,
  input logic [NPIX-1:0] root_map,
  input logic            res_valid,
  input logic            done
);
  AST_MOVE_CONSERVES: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_MOVE) |=> ($countones(cur_q) == $past($countones(cur_q)) + $past($countones(inj_v)))); // R2

  AST_PAIR_NO_GROWTH: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_PAIR) |=> ($countones(cur_q) <= $past($countones(cur_q)))); // R4

  AST_PAIR_KEEPS_PARITY: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_PAIR) |=> ((($past($countones(cur_q)) - $countones(cur_q) - $past($countones(pdec))) % 2) == 0)); // R4

  AST_EMIT_AT_ROOT: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EMIT && !mode_q) |-> (((cur_q & ~root_map) == '0) && $onehot0(cur_q))); // R5

  AST_BIT_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R5

  AST_DONE_WITH_BIT: assert property (@(posedge clk) disable iff (rst)
    done |-> res_valid); // R7

  AST_OR_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
    (res_valid && mode_q) |-> done); // R8

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_IDLE) |-> (cur_q == '0)); // R9
endmodule

bind token_sum_engine tse_checker #(.NPIX(ROWS*COLS)) u_tse_chk (
  .clk(clk), .rst(rst), .phase(phase), .mode_q(mode_q), .cur_q(cur_q),
  .inj_v(inj_v), .pdec(pdec), .root_map(root_map),
  .res_valid(res_valid), .done(done)
);

// File: tb/tb_token_sum_engine.sv
module tb_token_sum_engine;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int NPIX = ROWS * COLS;
  localparam int NVEC = 10;

  // stimulus table: seed pattern, tree kind (0 random, 1 comb, 2 row-first), mode
  localparam logic [63:0] T_SEED [NVEC] = '{
    64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001,
    64'hA5A5_3C3C_0F0F_9669, 64'h0000_0000_0010_0000, 64'h0123_4567_89AB_CDEF,
    64'h0000_0000_0000_0000, 64'h0000_8000_0000_0000, 64'hFFFF_0000_FFFF_0000,
    64'h7FFF_FFFF_FFFF_FFFF};
  localparam int T_KIND [NVEC] = '{0, 0, 1, 2, 0, 1, 0, 2, 0, 2};
  localparam bit T_MODE [NVEC] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode_or = 1'b0;
  logic [NPIX-1:0]   seed_map = '0;
  logic [NPIX-1:0]   root_map = '0;
  logic [2*NPIX-1:0] parent_dir = '0;
  logic res_bit, res_valid, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  token_sum_engine #(.ROWS(ROWS), .COLS(COLS)) dut (
    .clk(clk), .rst(rst), .start(start), .mode_or(mode_or),
    .seed_map(seed_map), .root_map(root_map), .parent_dir(parent_dir),
    .res_bit(res_bit), .res_valid(res_valid), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nbr(input int p, input int d);
    int r = p / COLS;
    int c = p % COLS;
    if (d == 0) r = r - 1;
    if (d == 1) c = c + 1;
    if (d == 2) r = r + 1;
    if (d == 3) c = c - 1;
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return -1;
    return r * COLS + c;
  endfunction

  function automatic int bitlen(input int n);
    return (n == 0) ? 1 : $clog2(n + 1);
  endfunction

  task automatic build_tree(input int kind);
    bit att [NPIX];
    int cnt;
    int rootp;
    rootp = (kind == 0) ? int'($urandom_range(NPIX - 1, 0)) : 0;
    root_map = '0;
    root_map[rootp] = 1'b1;
    parent_dir = '0;
    for (int i = 0; i < NPIX; i++) att[i] = 1'b0;
    if (kind == 1) begin
      for (int p = 0; p < NPIX; p++)
        parent_dir[2*p +: 2] = (p < COLS) ? 2'd3 : 2'd0;
    end else if (kind == 2) begin
      for (int p = 0; p < NPIX; p++)
        parent_dir[2*p +: 2] = ((p % COLS) == 0) ? 2'd0 : 2'd3;
    end else begin
      att[rootp] = 1'b1;
      cnt = 1;
      while (cnt < NPIX) begin
        int p = int'($urandom_range(NPIX - 1, 0));
        if (!att[p]) begin
          int off = int'($urandom_range(3, 0));
          bit got = 1'b0;
          for (int k = 0; k < 4; k++) begin
            int d = (off + k) % 4;
            int q = nbr(p, d);
            if (!got && q >= 0 && att[q]) begin
              parent_dir[2*p +: 2] = 2'(d);
              att[p] = 1'b1;
              cnt++;
              got = 1'b1;
            end
          end
        end
      end
    end
  endtask

  // one run; poke >= 0 raises start with other inputs while busy (R1)
  task automatic run(input bit m, input logic [NPIX-1:0] s, input int poke, input string tag);
    int exp_v, exp_n, got_v, got_n, t;
    bit fin;
    exp_v = m ? int'(|s) : $countones(s);
    exp_n = m ? 1 : bitlen(exp_v);
    @(negedge clk);
    mode_or = m; seed_map = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_v = 0; got_n = 0; t = 0; fin = 1'b0;
    while (!fin && t < 12000) begin
      if (res_valid) begin
        if (got_n < 16) got_v = got_v | (int'(res_bit) << got_n);
        got_n++;
        if (done) fin = 1'b1;
      end
      if (t == poke) begin
        start = 1'b1; seed_map = ~s; mode_or = ~m;
      end else begin
        start = 1'b0; seed_map = s; mode_or = m;
      end
      @(negedge clk);
      t++;
    end
    start = 1'b0;
    chk({tag, " R7 run ends with done"}, fin, 1);
    chk({tag, " R6 R8 result value (R2 R3 R4 R10 path)"}, got_v, exp_v);
    chk({tag, " R5 R6 bit count"}, got_n, exp_n);
    @(negedge clk);
    chk({tag, " R7 quiet after done"}, {res_valid, done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset res_valid", res_valid, 0);
    chk("R9 reset done", done, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 idle without start", {res_valid, done}, 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      build_tree(T_KIND[i]);
      run(T_MODE[i], T_SEED[i], -1, $sformatf("vec%0d", i));
    end

    // random seeds on random trees, count vs population of seeds
    for (int i = 0; i < 6; i++) begin
      build_tree(0);
      run(1'b0, {$urandom(), $urandom()}, -1, $sformatf("rnd%0d", i));
    end

    // R1: start while busy is ignored
    build_tree(0);
    run(1'b0, {NPIX{1'b1}}, 5, "R1 busy start");
    build_tree(2);
    run(1'b0, 64'h00FF_00FF_00FF_00FF, 9, "R1 busy start row tree");

    // R8: single seed far from root in OR mode, comb tree
    build_tree(1);
    run(1'b1, 64'h8000_0000_0000_0000, -1, "R8 far seed");

    // R9: reset in the middle of a run, then a clean run
    build_tree(0);
    @(negedge clk);
    mode_or = 1'b0; seed_map = {NPIX{1'b1}}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 mid-run reset outputs", {res_valid, done}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 stays idle after reset", {res_valid, done}, 0);
    run(1'b0, 64'h0000_0000_0000_0007, -1, "R9 after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule